// File: doc/BRIEF.md
# Serial Transceiver Reset Sequencer

This block releases the digital resets of a group of serial channels in the right order. It runs from a free-running system clock and has one transmit lane and one receive lane per channel. A lane's digital reset is held while any condition that blocks it is present. Once those conditions clear, the lane waits a programmable number of cycles before it releases. One cycle after the release, a per-lane ready flag goes high. The block does not drive analog resets, the PLL or the calibration engines. It only reads their status as flags.

The transmit lanes depend on the shared PLL. A transmit lane cannot release until the PLL has shown lock once since reset. Each transmit lane has a mode select. In automatic mode, a later loss of PLL lock re-arms that lane's reset. In manual mode, a later loss of PLL lock is ignored. The receive lanes depend on their own clock-data-recovery lock. A receive lane in manual mode ignores that lock in both directions.

A build option can merge the per-channel CDR locks with an AND into one shared status. Another build option selects how the reset request is taken in: sampled by two flops (the default), or asserted asynchronously and released synchronously. Every status and mode input passes through a two-flop synchronizer before use.

Top module: `xrs_top`

## Requirements
- R1: While `rst_req` is held high, every bit of `tx_dig_rst` and `rx_dig_rst` is 1 and every ready bit is 0 from the second clock edge on. This holds for as long as the request is held, and a request held for at least 2 edges is always recognized.
- R2: For a given channel, `tx_dig_rst` is 1 from the 3rd edge after any of these inputs goes high: `pll_pwrdn`, `pll_calib`, or that channel's `tx_calib` bit. It stays 1 while the input stays high.
- R3: After reset, a transmit lane keeps `tx_dig_rst` at 1 until `pll_lock` has been seen high at least once. This applies in both values of `tx_man_mode`.
- R4: Suppose the last transmit blocking condition clears before clock edge 1 and none returns. Then `tx_dig_rst` falls at edge TX_DLY+3. If a blocking condition returns during the countdown, the countdown starts again from the beginning.
- R5: With `tx_man_mode[i]`=0, a low `pll_lock` blocks transmit lane i. The reset re-asserts at the 3rd edge after lock drops, and the release then follows the R4 timing.
- R6: With `tx_man_mode[i]`=1, once the first lock has been seen, a low `pll_lock` has no effect on `tx_dig_rst[i]` or `tx_rdy[i]`.
- R7: While `rx_calib[i]` is high, `rx_dig_rst[i]` is 1 from the 3rd edge after the rise, in both modes.
- R8: With `rx_man_mode[i]`=0, `rx_dig_rst[i]` falls at edge RX_DLY+3 after `cdr_lock[i]` rises, provided the lock stays high the whole time. A drop of the lock re-asserts the reset at the 3rd edge.
- R9: With `rx_man_mode[i]`=1, `cdr_lock[i]` has no effect on `rx_dig_rst[i]`. The lane releases RX_DLY+3 edges after `rx_calib[i]` is low and the block is out of reset.
- R10: With RX_SHARED=1, every receive lane uses the AND of all `cdr_lock` bits as its lock status.
- R11: Each ready bit rises exactly one edge after its digital reset falls. It is never 1 while that reset is 1, and it falls on the same edge that the reset rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst_req | input | 1 | Global reset request, active high |
| pll_pwrdn | input | 1 | PLL powered down |
| pll_lock | input | 1 | PLL lock status |
| pll_calib | input | 1 | PLL calibration in progress |
| tx_calib | input | NCH | Per-channel TX calibration in progress |
| rx_calib | input | NCH | Per-channel RX calibration in progress |
| cdr_lock | input | NCH | Per-channel CDR locked to incoming data |
| tx_man_mode | input | NCH | 1: TX lane ignores later PLL lock loss |
| rx_man_mode | input | NCH | 1: RX lane ignores CDR lock |
| tx_dig_rst | output | NCH | Per-channel TX digital reset, active high |
| rx_dig_rst | output | NCH | Per-channel RX digital reset, active high |
| tx_rdy | output | NCH | TX lane out of reset and settled |
| rx_rdy | output | NCH | RX lane out of reset and settled |

## Verification
Every input passes through two synchronizer flops, and each state change is registered once more. So any blocking input acts on a reset output at the 3rd edge after it changes. A release lands at edge DLY+3 after the last blocking condition clears, and ready follows one edge after that. The bench drives inputs on the falling edge and samples outputs on the next falling edge. Each cycle it compares the outputs against a reference model that advances per rising edge with exactly that latency. Directed cases also count the edges from a lock rise to the reset release, and check for TX_DLY+3 and RX_DLY+3.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [1:0] {
        TX_WAIT_LOCK = 2'd0,
        TX_HOLD      = 2'd1,
        TX_COUNT     = 2'd2,
        TX_RUN       = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HOLD  = 2'd0,
        RX_COUNT = 2'd1,
        RX_RUN   = 2'd2
    } rx_state_e;

endpackage

// File: rtl/xrs_sync.sv
// Two-flop synchronizer for a bus of independent status bits.
module xrs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    logic [W-1:0] stab;

    always_ff @(posedge clk) begin
        meta <= d;
        stab <= meta;
    end

    assign q = stab;
endmodule

// File: rtl/xrs_rst_gen.sv
// Internal reset: either two-flop sampled, or async assert / sync release.
module xrs_rst_gen #(
    parameter bit SYNC_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_req,
    output logic rst_out
);
    logic [1:0] sr;

    generate
        if (SYNC_RST) begin : g_sampled
            always_ff @(posedge clk) begin
                sr <= {sr[0], rst_req};
            end
        end else begin : g_async
            always_ff @(posedge clk or posedge rst_req) begin
                if (rst_req) sr <= 2'b11;
                else         sr <= {sr[0], 1'b0};
            end
        end
    endgenerate

    assign rst_out = sr[1];
endmodule

// File: rtl/xrs_tx_chan.sv
// One transmit lane: first-lock gate, blocking conditions, release countdown.
module xrs_tx_chan
    import xrs_pkg::*;
#(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pll_pd,
    input  logic pll_cal,
    input  logic pll_lk,
    input  logic lane_cal,
    input  logic man_mode,
    output logic dig_rst,
    output logic rdy
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    tx_state_e st, nxt;
    logic [CW-1:0] cnt;
    logic blocked;

    // Lock loss only blocks in automatic mode
    assign blocked = pll_pd | pll_cal | lane_cal | (~man_mode & ~pll_lk);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st <= TX_WAIT_LOCK;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            TX_WAIT_LOCK: if (pll_lk)      nxt = blocked ? TX_HOLD : TX_COUNT;
            TX_HOLD:      if (!blocked)    nxt = TX_COUNT;
            TX_COUNT: begin
                if (blocked)               nxt = TX_HOLD;
                else if (cnt == '0)        nxt = TX_RUN;
            end
            TX_RUN:       if (blocked)     nxt = TX_HOLD;
            default:                       nxt = TX_WAIT_LOCK;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                                   cnt <= LOAD;
        else if (st == TX_COUNT && nxt == TX_COUNT) cnt <= cnt - 1'b1;
        else                                       cnt <= LOAD;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dig_rst <= 1'b1;
            rdy     <= 1'b0;
        end else begin
            dig_rst <= (nxt != TX_RUN);
            rdy     <= (nxt == TX_RUN) && (st == TX_RUN);
        end
    end
endmodule

// File: rtl/xrs_rx_chan.sv
// One receive lane: calibration gate, CDR lock qualification, countdown.
module xrs_rx_chan
    import xrs_pkg::*;
#(
    parameter int DLY = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic lane_cal,
    input  logic cdr_lk,
    input  logic man_mode,
    output logic dig_rst,
    output logic rdy
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

    rx_state_e st, nxt;
    logic [CW-1:0] cnt;
    logic go;

    // Manual mode disregards the CDR lock in both directions
    assign go = ~lane_cal & (man_mode | cdr_lk);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st <= RX_HOLD;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RX_HOLD:  if (go)          nxt = RX_COUNT;
            RX_COUNT: begin
                if (!go)               nxt = RX_HOLD;
                else if (cnt == '0)    nxt = RX_RUN;
            end
            RX_RUN:   if (!go)         nxt = RX_HOLD;
            default:                   nxt = RX_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                                   cnt <= LOAD;
        else if (st == RX_COUNT && nxt == RX_COUNT) cnt <= cnt - 1'b1;
        else                                       cnt <= LOAD;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dig_rst <= 1'b1;
            rdy     <= 1'b0;
        end else begin
            dig_rst <= (nxt != RX_RUN);
            rdy     <= (nxt == RX_RUN) && (st == RX_RUN);
        end
    end
endmodule

// File: rtl/xrs_top.sv
module xrs_top #(
    parameter int NCH       = 2,
    parameter int TX_DLY    = 8,
    parameter int RX_DLY    = 6,
    parameter bit SYNC_RST  = 1'b1,
    parameter bit RX_SHARED = 1'b0
) (
    input  logic           sys_clk,
    input  logic           rst_req,
    input  logic           pll_pwrdn,
    input  logic           pll_lock,
    input  logic           pll_calib,
    input  logic [NCH-1:0] tx_calib,
    input  logic [NCH-1:0] rx_calib,
    input  logic [NCH-1:0] cdr_lock,
    input  logic [NCH-1:0] tx_man_mode,
    input  logic [NCH-1:0] rx_man_mode,
    output logic [NCH-1:0] tx_dig_rst,
    output logic [NCH-1:0] rx_dig_rst,
    output logic [NCH-1:0] tx_rdy,
    output logic [NCH-1:0] rx_rdy
);
    localparam int SW = 3 + 5 * NCH;

    logic          rst_int;
    logic [SW-1:0] raw_bus, syn_bus;
    logic          pd_s, lk_s, pc_s;
    logic [NCH-1:0] txcal_s, rxcal_s, cdr_s, txm_s, rxm_s, cdr_use;

    xrs_rst_gen #(.SYNC_RST(SYNC_RST)) u_rst (
        .clk     (sys_clk),
        .rst_req (rst_req),
        .rst_out (rst_int)
    );

    assign raw_bus = {pll_pwrdn, pll_lock, pll_calib,
                      tx_calib, rx_calib, cdr_lock, tx_man_mode, rx_man_mode};

    xrs_sync #(.W(SW)) u_sync (
        .clk (sys_clk),
        .d   (raw_bus),
        .q   (syn_bus)
    );

    assign {pd_s, lk_s, pc_s, txcal_s, rxcal_s, cdr_s, txm_s, rxm_s} = syn_bus;

    generate
        if (RX_SHARED) begin : g_cdr_shared
            assign cdr_use = {NCH{&cdr_s}};
        end else begin : g_cdr_split
            assign cdr_use = cdr_s;
        end
    endgenerate

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        xrs_tx_chan #(.DLY(TX_DLY)) u_tx (
            .clk      (sys_clk),
            .rst      (rst_int),
            .pll_pd   (pd_s),
            .pll_cal  (pc_s),
            .pll_lk   (lk_s),
            .lane_cal (txcal_s[i]),
            .man_mode (txm_s[i]),
            .dig_rst  (tx_dig_rst[i]),
            .rdy      (tx_rdy[i])
        );

        xrs_rx_chan #(.DLY(RX_DLY)) u_rx (
            .clk      (sys_clk),
            .rst      (rst_int),
            .lane_cal (rxcal_s[i]),
            .cdr_lk   (cdr_use[i]),
            .man_mode (rxm_s[i]),
            .dig_rst  (rx_dig_rst[i]),
            .rdy      (rx_rdy[i])
        );
    end
endmodule

// File: rtl/xrs_chk.sv
module xrs_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_req,
    input logic           rst_int,
    input logic           pd_s,
    input logic           pc_s,
    input logic [NCH-1:0] txcal_s,
    input logic [NCH-1:0] rxcal_s,
    input logic [NCH-1:0] tx_dig_rst,
    input logic [NCH-1:0] rx_dig_rst,
    input logic [NCH-1:0] tx_rdy,
    input logic [NCH-1:0] rx_rdy
);
    AST_RST_HOLDS_ALL: assert property (@(posedge clk)
        (rst_req && $past(rst_req) && $past(rst_req, 2)) |->
        (&tx_dig_rst && &rx_dig_rst && tx_rdy == '0 && rx_rdy == '0)); // R1

    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_TX_RDY_EXCL: assert property (@(posedge clk) disable iff (rst_int)
            tx_rdy[i] |-> !tx_dig_rst[i]); // R11
        AST_RX_RDY_EXCL: assert property (@(posedge clk) disable iff (rst_int)
            rx_rdy[i] |-> !rx_dig_rst[i]); // R11
        AST_TX_RDY_LAG: assert property (@(posedge clk) disable iff (rst_int)
            $rose(tx_rdy[i]) |-> $past(!tx_dig_rst[i])); // R11
        AST_RX_RDY_LAG: assert property (@(posedge clk) disable iff (rst_int)
            $rose(rx_rdy[i]) |-> $past(!rx_dig_rst[i])); // R11
        AST_TX_RDY_DROP: assert property (@(posedge clk) disable iff (rst_int)
            $fell(tx_rdy[i]) |-> tx_dig_rst[i]); // R11
        AST_TX_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (rst_int)
            $fell(tx_dig_rst[i]) |-> $past(!pd_s && !pc_s && !txcal_s[i])); // R2
        AST_RX_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (rst_int)
            $fell(rx_dig_rst[i]) |-> $past(!rxcal_s[i])); // R7
    end
endmodule

bind xrs_top xrs_chk #(.NCH(NCH)) u_chk (
    .clk        (sys_clk),
    .rst_req    (rst_req),
    .rst_int    (rst_int),
    .pd_s       (pd_s),
    .pc_s       (pc_s),
    .txcal_s    (txcal_s),
    .rxcal_s    (rxcal_s),
    .tx_dig_rst (tx_dig_rst),
    .rx_dig_rst (rx_dig_rst),
    .tx_rdy     (tx_rdy),
    .rx_rdy     (rx_rdy)
);

// File: tb/tb_xrs_top.sv
`timescale 1ns/1ps
module tb_xrs_top;
    localparam int NCH = 2;
    localparam int TXD = 8;
    localparam int RXD = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_req = 1'b1, pd = 1'b0, lk = 1'b0, pc = 1'b0;
    logic [NCH-1:0] txc = '0, rxc = '0, cdr = '0, txm = 2'b01, rxm = 2'b10;
    logic [NCH-1:0] tx_r, rx_r, tx_y, rx_y, tx_r2, rx_r2, tx_y2, rx_y2;

    xrs_top #(.NCH(NCH), .TX_DLY(TXD), .RX_DLY(RXD)) dut (
        .sys_clk(clk), .rst_req(rst_req), .pll_pwrdn(pd), .pll_lock(lk),
        .pll_calib(pc), .tx_calib(txc), .rx_calib(rxc), .cdr_lock(cdr),
        .tx_man_mode(txm), .rx_man_mode(rxm),
        .tx_dig_rst(tx_r), .rx_dig_rst(rx_r), .tx_rdy(tx_y), .rx_rdy(rx_y));

    xrs_top #(.NCH(NCH), .TX_DLY(TXD), .RX_DLY(RXD), .RX_SHARED(1'b1)) dut_sh (
        .sys_clk(clk), .rst_req(rst_req), .pll_pwrdn(pd), .pll_lock(lk),
        .pll_calib(pc), .tx_calib(txc), .rx_calib(rxc), .cdr_lock(cdr),
        .tx_man_mode(txm), .rx_man_mode(rxm),
        .tx_dig_rst(tx_r2), .rx_dig_rst(rx_r2), .tx_rdy(tx_y2), .rx_rdy(rx_y2));

    int n_chk = 0, n_fail = 0;
    bit chk_en = 0, done = 0;
    string tag = "R1";

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: two-edge input delay, first-lock memory, run-length counters
    logic r1 = 0, ri = 0;
    logic pd1 = 0, pd2 = 0, lk1 = 0, lk2 = 0, pc1 = 0, pc2 = 0;
    logic [NCH-1:0] txc1 = 0, txc2 = 0, rxc1 = 0, rxc2 = 0, cdr1 = 0, cdr2 = 0;
    logic [NCH-1:0] txm1 = 0, txm2 = 0, rxm1 = 0, rxm2 = 0, seen = 0;
    int ktx[NCH], krx[NCH], krs[NCH];

    function automatic int bump(int k, bit ok);
        if (!ok) return 0;
        return (k < 1000) ? k + 1 : k;
    endfunction

    always @(posedge clk) begin
        logic ori, rnow, blk;
        ori = ri; ri = r1; r1 = rst_req;
        rnow = ori | ri;
        for (int c = 0; c < NCH; c++) begin
            if (rnow) begin
                ktx[c] = 0; krx[c] = 0; krs[c] = 0; seen[c] = 1'b0;
            end else begin
                blk = pd2 | pc2 | txc2[c] | (~txm2[c] & ~lk2);
                ktx[c] = bump(ktx[c], !blk && (seen[c] || lk2));
                seen[c] = seen[c] | lk2;
                krx[c] = bump(krx[c], !rxc2[c] && (rxm2[c] || cdr2[c]));
                krs[c] = bump(krs[c], !rxc2[c] && (rxm2[c] || (&cdr2)));
            end
        end
        pd2 = pd1; pd1 = pd; lk2 = lk1; lk1 = lk; pc2 = pc1; pc1 = pc;
        txc2 = txc1; txc1 = txc; rxc2 = rxc1; rxc1 = rxc;
        cdr2 = cdr1; cdr1 = cdr; txm2 = txm1; txm1 = txm; rxm2 = rxm1; rxm1 = rxm;
    end

    always @(negedge clk) begin
        if (chk_en) begin
            for (int c = 0; c < NCH; c++) begin
                chk(tag, $sformatf("model tx_rst ch%0d", c), tx_r[c], ktx[c] <= TXD);
                chk(tag, $sformatf("model tx_rdy ch%0d", c), tx_y[c], ktx[c] >= TXD + 2);
                chk(tag, $sformatf("model rx_rst ch%0d", c), rx_r[c], krx[c] <= RXD);
                chk(tag, $sformatf("model rx_rdy ch%0d", c), rx_y[c], krx[c] >= RXD + 2);
                chk("R10", $sformatf("shared rx_rst ch%0d", c), rx_r2[c], krs[c] <= RXD);
                chk("R10", $sformatf("shared rx_rdy ch%0d", c), rx_y2[c], krs[c] >= RXD + 2);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges_to_fall(bit is_tx, int c, output int n);
        n = 0;
        while (((is_tx ? tx_r[c] : rx_r[c]) == 1'b1) && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int n;
        void'($urandom(32'h1a2b3c4d));
        cyc(3);
        chk_en = 1;
        tag = "R1";
        cyc(10);
        chk("R1", "tx_rst all in reset", &tx_r, 1'b1);
        chk("R1", "rx_rst all in reset", &rx_r, 1'b1);
        chk("R1", "ready low in reset", |{tx_y, rx_y}, 1'b0);

        // R3: no PLL lock yet, manual lane ch0 still held
        tag = "R3";
        rst_req = 1'b0;
        cyc(40);
        chk("R3", "tx_rst ch0 before first lock", tx_r[0], 1'b1);
        chk("R3", "tx_rst ch1 before first lock", tx_r[1], 1'b1);
        chk("R9", "rx ch1 manual releases without cdr", rx_r[1], 1'b0);
        chk("R8", "rx ch0 auto held without cdr", rx_r[0], 1'b1);

        tag = "R4";
        lk = 1'b1;
        edges_to_fall(1'b1, 0, n);
        chk("R4", "tx release latency == TX_DLY+3", n == TXD + 3, 1'b1);
        cyc(1);
        chk("R11", "tx_rdy one edge after release", tx_y[0], 1'b1);

        tag = "R8";
        cdr = 2'b11;
        edges_to_fall(1'b0, 0, n);
        chk("R8", "rx release latency == RX_DLY+3", n == RXD + 3, 1'b1);
        cyc(3);

        tag = "R5";
        lk = 1'b0;
        cyc(5);
        chk("R5", "auto tx lane re-asserts on lock loss", tx_r[1], 1'b1);
        chk("R6", "manual tx lane ignores lock loss", tx_r[0], 1'b0);
        chk("R6", "manual tx lane stays ready", tx_y[0], 1'b1);
        lk = 1'b1;
        cyc(20);

        tag = "R8";
        cdr = 2'b00;
        cyc(4);
        chk("R8", "auto rx lane re-asserts on cdr loss", rx_r[0], 1'b1);
        chk("R9", "manual rx lane ignores cdr loss", rx_r[1], 1'b0);
        cdr = 2'b11;
        cyc(20);

        tag = "R2";
        pd = 1'b1; cyc(4);
        chk("R2", "powerdown blocks tx", &tx_r, 1'b1);
        pd = 1'b0; cyc(15);
        pc = 1'b1; cyc(4);
        chk("R2", "pll calibration blocks tx", &tx_r, 1'b1);
        pc = 1'b0; cyc(15);
        txc = 2'b01; cyc(4);
        chk("R2", "lane tx calibration blocks ch0", tx_r[0], 1'b1);
        chk("R2", "lane tx calibration leaves ch1", tx_r[1], 1'b0);
        txc = 2'b00; cyc(15);

        tag = "R7";
        rxc = 2'b10; cyc(30);
        chk("R7", "rx calibration holds manual lane", rx_r[1], 1'b1);
        rxc = 2'b00; cyc(15);

        tag = "R10";
        cdr = 2'b10; cyc(12);
        chk("R10", "shared lock low holds auto lane", rx_r2[0], 1'b1);
        chk("R8", "split lock keeps ch1-independent ch0 held", rx_r[0], 1'b1);
        cdr = 2'b01; cyc(12);
        chk("R10", "split ch0 released while shared held", rx_r[0] == 1'b0 && rx_r2[0] == 1'b1, 1'b1);
        cdr = 2'b11; cyc(15);

        tag = "R1";
        rst_req = 1'b1; cyc(3);
        chk("R1", "mid-run reset asserts tx", &tx_r, 1'b1);
        chk("R1", "mid-run reset asserts rx", &rx_r, 1'b1);
        rst_req = 1'b0; cyc(25);

        // Random phase; model carries the R4/R8 timing
        tag = "R4/R8";
        for (int t = 0; t < 6000; t++) begin
            if ($urandom_range(0, 59) == 0) pd  = ~pd;
            if ($urandom_range(0, 59) == 0) pc  = ~pc;
            if ($urandom_range(0, 29) == 0) lk  = ~lk;
            if ($urandom_range(0, 49) == 0) txc[$urandom_range(0, NCH-1)] ^= 1'b1;
            if ($urandom_range(0, 49) == 0) rxc[$urandom_range(0, NCH-1)] ^= 1'b1;
            if ($urandom_range(0, 19) == 0) cdr[$urandom_range(0, NCH-1)] ^= 1'b1;
            if ($urandom_range(0, 299) == 0) txm[$urandom_range(0, NCH-1)] ^= 1'b1;
            if ($urandom_range(0, 299) == 0) rxm[$urandom_range(0, NCH-1)] ^= 1'b1;
            if ($urandom_range(0, 999) == 0) rst_req = 1'b1;
            else if (rst_req && $urandom_range(0, 3) == 0) rst_req = 1'b0;
            cyc(1);
        end
        chk_en = 0;
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule